// File: doc/BRIEF.md
# Passive Serial Configuration Host

This block loads a bitstream into a programmable target device over a three-wire passive serial link. It pulls the target's active-low configuration request line low for a minimum time and waits for the target's active-low status line to come back high. After a programmable lead time it generates the serial clock itself and shifts configuration bytes out on one data wire, least significant bit first. The bytes come from a ready/valid byte stream. A flag on the last byte marks the end of the image.

When the target raises its done line, the block stops clocking and parks the clock and data wires low. It then waits a programmable user-mode delay and, when enabled, the target's init-done line before it reports that the target is running. Two faults end the sequence with a sticky error flag and a return to idle. One is the status line dropping during loading. The other is done failing to rise within a programmable number of extra clocks after the last byte. All target inputs pass through a synchronizer first.

Top module: `ps_cfg_host`

## Requirements
- R1: After reset the request line is high, the serial clock and data are low, and `s_ready_o`, `tgt_ready_o` and `cfg_err_o` are low.
- R2: A `start_i` pulse taken while the synchronized status is high drives `cfg_req_n_o` low for at least `REQ_LOW_CYC` cycles, then releases it.
- R3: `start_i` is ignored while the synchronized status line is low, for example during the target's power-on interval.
- R4: No rising serial clock edge occurs before the status line has returned high after the request pulse, plus at least `ST2CK_CYC` cycles.
- R5: Each byte is sent as eight serial clock periods, bit 0 first, with bytes in stream order.
- R6: Data changes only while the clock is low and never on a rising edge. The clock stays high for at least max(`CLK_HI_CYC`,`HOLD_CYC`) cycles and low for at least max(`CLK_LO_CYC`,`SETUP_CYC`) cycles between rising edges.
- R7: `s_ready_o` is high only after all eight bits of the held byte have gone out, and never while the serial clock is high.
- R8: After done rises, `tgt_ready_o` rises no earlier than `USERMODE_CYC` cycles later, and only once init-done is high when `USE_INIT` is 1.
- R9: Once the target is ready, the serial clock and data stay low with no further clock edges until the next start.
- R10: If the status line goes low during shifting or while waiting for done, `cfg_err_o` is set, clocking stops and the block returns to idle with the request line high.
- R11: If done stays low for `EXTRA_CLKS` clock periods after the last bit of the byte flagged last, `cfg_err_o` is set and the block returns to idle.
- R12: A new start is accepted from the ready state as well as from idle, and `cfg_err_o` clears when a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a configuration cycle |
| s_data_i | input | 8 | Configuration byte |
| s_last_i | input | 1 | Marks the final byte of the image |
| s_valid_i | input | 1 | Byte stream valid |
| s_ready_o | output | 1 | Byte stream ready |
| cfg_req_n_o | output | 1 | Active-low configuration request to the target |
| ser_clk_o | output | 1 | Serial clock to the target |
| ser_dat_o | output | 1 | Serial data to the target |
| tgt_stat_n_i | input | 1 | Target status, low means busy or fault |
| tgt_done_i | input | 1 | Target has taken the whole image |
| tgt_init_i | input | 1 | Target initialization complete |
| tgt_ready_o | output | 1 | Target is in user mode |
| cfg_err_o | output | 1 | Sticky error, cleared on the next accepted start |

## Verification
The hardest cases to reach are the two fault paths, which need the target to misbehave at a chosen point. In one, the status line must collapse in the middle of a byte. In the other, done must never arrive, so the extra-clock budget is spent to its last period. The bench models the target at the pins. The model counts rising serial clock edges, so it can drop status at a chosen bit number or withhold done entirely. It also counts the clock edges that follow the last data bit and compares that count with the budget.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ_LOW,
        ST_WAIT_STAT,
        ST_WAIT_LEAD,
        ST_SHIFT,
        ST_WAIT_DONE,
        ST_WAIT_USER,
        ST_READY,
        ST_ERROR
    } st_e;

    typedef struct packed {
        logic init_ok;
        logic done_ok;
        logic stat_ok;
    } tgt_in_t;

    function automatic int maxi(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ps_cfg_sync.sv
module ps_cfg_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ps_cfg_timer.sv
module ps_cfg_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (load)      cnt <= val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/ps_cfg_bitclk.sv
module ps_cfg_bitclk
    import ps_cfg_pkg::*;
#(
    parameter int LO_N = 2,
    parameter int HI_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic sclk,
    output logic bit_end
);
    localparam int CW = $clog2(maxi(LO_N, HI_N) + 1);

    logic          ph_hi;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ph_hi <= 1'b0;
            cnt   <= '0;
        end else if (!ph_hi) begin
            if (cnt == CW'(LO_N - 1)) begin
                ph_hi <= 1'b1;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            if (cnt == CW'(HI_N - 1)) begin
                ph_hi <= 1'b0;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign sclk    = ph_hi;
    assign bit_end = en && ph_hi && (cnt == CW'(HI_N - 1));
endmodule

// File: rtl/ps_cfg_shreg.sv
module ps_cfg_shreg (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       load,
    input  logic [7:0] din,
    input  logic       last_in,
    input  logic       shift,
    output logic       have,
    output logic       bit0,
    output logic       last_q,
    output logic       byte_done
);
    logic [7:0] sreg;
    logic [2:0] bcnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sreg   <= '0;
            bcnt   <= '0;
            have   <= 1'b0;
            last_q <= 1'b0;
        end else if (load) begin
            sreg   <= din;
            bcnt   <= '0;
            have   <= 1'b1;
            last_q <= last_in;
        end else if (shift && have) begin
            sreg <= {1'b0, sreg[7:1]};
            bcnt <= bcnt + 1'b1;
            if (bcnt == 3'd7) have <= 1'b0;
        end
    end

    assign bit0      = sreg[0];
    assign byte_done = shift && have && (bcnt == 3'd7);
endmodule

// File: rtl/ps_cfg_host.sv
module ps_cfg_host
    import ps_cfg_pkg::*;
#(
    parameter int REQ_LOW_CYC  = 8,
    parameter int ST2CK_CYC    = 5,
    parameter int CLK_LO_CYC   = 2,
    parameter int CLK_HI_CYC   = 2,
    parameter int SETUP_CYC    = 1,
    parameter int HOLD_CYC     = 1,
    parameter int USERMODE_CYC = 6,
    parameter int EXTRA_CLKS   = 16,
    parameter int SYNC_STAGES  = 2,
    parameter bit USE_INIT     = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [7:0] s_data_i,
    input  logic       s_last_i,
    input  logic       s_valid_i,
    output logic       s_ready_o,
    output logic       cfg_req_n_o,
    output logic       ser_clk_o,
    output logic       ser_dat_o,
    input  logic       tgt_stat_n_i,
    input  logic       tgt_done_i,
    input  logic       tgt_init_i,
    output logic       tgt_ready_o,
    output logic       cfg_err_o
);
    localparam int LO_N  = maxi(CLK_LO_CYC, SETUP_CYC);
    localparam int HI_N  = maxi(CLK_HI_CYC, HOLD_CYC);
    localparam int TMR_W = $clog2(maxi(maxi(REQ_LOW_CYC, ST2CK_CYC), USERMODE_CYC) + 1);
    localparam int XW    = $clog2(EXTRA_CLKS + 1);

    st_e             state, nxt;
    tgt_in_t         tin;
    logic [2:0]      tin_raw;
    logic            tmr_ld, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    logic            clk_en, bit_end;
    logic            have, bit0, last_q, byte_done;
    logic [XW-1:0]   xcnt;

    assign tin_raw = {tgt_init_i, tgt_done_i, tgt_stat_n_i};

    ps_cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(tin_raw), .q(tin)
    );

    ps_cfg_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_ld), .val(tmr_val), .zero(tmr_zero)
    );

    assign clk_en = (state == ST_SHIFT && have) || (state == ST_WAIT_DONE);

    ps_cfg_bitclk #(.LO_N(LO_N), .HI_N(HI_N)) u_bclk (
        .clk(clk), .rst(rst), .en(clk_en), .sclk(ser_clk_o), .bit_end(bit_end)
    );

    assign s_ready_o = (state == ST_SHIFT) && !have;

    ps_cfg_shreg u_shr (
        .clk(clk), .rst(rst), .clr(state != ST_SHIFT),
        .load(s_valid_i && s_ready_o), .din(s_data_i), .last_in(s_last_i),
        .shift(bit_end), .have(have), .bit0(bit0), .last_q(last_q),
        .byte_done(byte_done)
    );

    always_comb begin
        nxt     = state;
        tmr_ld  = 1'b0;
        tmr_val = '0;
        unique case (state)
            ST_IDLE, ST_READY: begin
                if (start_i && tin.stat_ok) begin
                    nxt     = ST_REQ_LOW;
                    tmr_ld  = 1'b1;
                    tmr_val = TMR_W'(REQ_LOW_CYC);
                end
            end
            ST_REQ_LOW:   if (tmr_zero) nxt = ST_WAIT_STAT;
            ST_WAIT_STAT: begin
                if (tin.stat_ok) begin
                    nxt     = ST_WAIT_LEAD;
                    tmr_ld  = 1'b1;
                    tmr_val = TMR_W'(ST2CK_CYC);
                end
            end
            ST_WAIT_LEAD: begin
                if (!tin.stat_ok) nxt = ST_ERROR;
                else if (tmr_zero) nxt = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (!tin.stat_ok) nxt = ST_ERROR;
                else if (tin.done_ok) begin
                    nxt     = ST_WAIT_USER;
                    tmr_ld  = 1'b1;
                    tmr_val = TMR_W'(USERMODE_CYC);
                end else if (byte_done && last_q) nxt = ST_WAIT_DONE;
            end
            ST_WAIT_DONE: begin
                if (!tin.stat_ok) nxt = ST_ERROR;
                else if (tin.done_ok) begin
                    nxt     = ST_WAIT_USER;
                    tmr_ld  = 1'b1;
                    tmr_val = TMR_W'(USERMODE_CYC);
                end else if (bit_end && xcnt == XW'(EXTRA_CLKS - 1)) nxt = ST_ERROR;
            end
            ST_WAIT_USER: begin
                if (tmr_zero && (tin.init_ok || !USE_INIT)) nxt = ST_READY;
            end
            ST_ERROR: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst || state != ST_WAIT_DONE) xcnt <= '0;
        else if (bit_end)                 xcnt <= xcnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                    cfg_err_o <= 1'b0;
        else if (nxt == ST_ERROR)   cfg_err_o <= 1'b1;
        else if (nxt == ST_REQ_LOW) cfg_err_o <= 1'b0;
    end

    assign cfg_req_n_o = (state != ST_REQ_LOW);
    assign ser_dat_o   = have & bit0;
    assign tgt_ready_o = (state == ST_READY);
endmodule

// File: rtl/ps_cfg_host_chk.sv
module ps_cfg_host_chk
    import ps_cfg_pkg::*;
#(
    parameter bit USE_INIT = 1'b1
) (
    input logic    clk,
    input logic    rst,
    input st_e     state,
    input logic    ser_clk,
    input logic    ser_dat,
    input logic    s_ready,
    input logic    tgt_ready,
    input tgt_in_t tin
);
    a_r4_clk_only_when_loading: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_clk) |-> ($past(state) == ST_SHIFT || $past(state) == ST_WAIT_DONE));

    a_r6_no_data_change_at_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_clk) |-> $stable(ser_dat));

    a_r6_data_held_while_high: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_dat));

    a_r7_ready_only_clk_low: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> !ser_clk);

    a_r8_ready_gated: assert property (@(posedge clk) disable iff (rst)
        $rose(tgt_ready) |-> (tin.done_ok && (tin.init_ok || !USE_INIT)));

    a_r9_parked_when_ready: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READY) |-> (!ser_clk && !ser_dat));

    a_r10_status_drop_errors: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT && !tin.stat_ok) |=> (state == ST_ERROR));
endmodule

bind ps_cfg_host ps_cfg_host_chk #(.USE_INIT(USE_INIT)) u_chk (
    .clk(clk), .rst(rst), .state(state), .ser_clk(ser_clk_o),
    .ser_dat(ser_dat_o), .s_ready(s_ready_o), .tgt_ready(tgt_ready_o), .tin(tin)
);

// File: tb/ps_cfg_host_tb.sv
module ps_cfg_host_tb;
    localparam int CLK_P   = 10;
    localparam int REQ_LOW = 8;
    localparam int ST2CK   = 5;
    localparam int LO_MIN  = 2;
    localparam int HI_MIN  = 2;
    localparam int UM      = 6;
    localparam int EXTRA   = 16;
    localparam int POR     = 40;
    localparam int LIMIT   = 150000;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [7:0] s_data = '0;
    logic s_last = 1'b0, s_valid = 1'b0, s_ready;
    logic cfg_req_n, ser_clk, ser_dat, tgt_ready, cfg_err;
    logic tgt_stat_n = 1'b0, tgt_done = 1'b0, tgt_init = 1'b0;

    ps_cfg_host u_dut (
        .clk(clk), .rst(rst), .start_i(start), .s_data_i(s_data),
        .s_last_i(s_last), .s_valid_i(s_valid), .s_ready_o(s_ready),
        .cfg_req_n_o(cfg_req_n), .ser_clk_o(ser_clk), .ser_dat_o(ser_dat),
        .tgt_stat_n_i(tgt_stat_n), .tgt_done_i(tgt_done), .tgt_init_i(tgt_init),
        .tgt_ready_o(tgt_ready), .cfg_err_o(cfg_err)
    );

    always #(CLK_P/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0, bad = 0;
    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // scoreboard and target model state
    logic [7:0] exp_q [$];
    int  hold_low = POR, done_at = -1, drop_at = -1, init_dly = 0, init_cnt = 0;
    int  bits = 0, exp_bits = 0, nb = 0, sb_cnt = 0, sb_bad = 0, extra = 0, viol = 0;
    int  hi_len = 0, lo_len = 100, req_lows = 0, rdy_hi_clk = 0;
    int  rises_after_rdy = 0, rises_after_err = 0;
    int  t_req_fall = 0, t_req_rise = 0, t_stat = 0, t_first = 0, t_done = 0;
    int  t_init = 0, t_rdy = 0;
    logic [7:0] acc = '0;
    logic p_clk = 1'b0, p_dat = 1'b0, p_req = 1'b1, p_rdy = 1'b0;
    bit  abort = 1'b0;

    always @(negedge clk) begin
        if (!cfg_req_n) req_lows++;
        if (!cfg_req_n && p_req)  t_req_fall = cyc;
        if (cfg_req_n && !p_req)  t_req_rise = cyc;
        if (tgt_ready && !p_rdy)  t_rdy = cyc;
        if (s_ready && ser_clk)   rdy_hi_clk++;
        if (!cfg_req_n) begin
            tgt_stat_n = 1'b0; tgt_done = 1'b0; tgt_init = 1'b0;
            bits = 0; hold_low = 4;
        end else if (hold_low > 0) begin
            hold_low--;
        end else if (!tgt_stat_n) begin
            tgt_stat_n = 1'b1; t_stat = cyc;
        end
        if (ser_clk && p_clk && ser_dat != p_dat) viol++;
        if (ser_clk && !p_clk) begin
            if (ser_dat != p_dat) viol++;
            if (lo_len < LO_MIN) viol++;
            bits++;
            if (tgt_ready) rises_after_rdy++;
            if (cfg_err)   rises_after_err++;
            if (bits == 1) t_first = cyc;
            if (bits <= exp_bits) begin
                acc = {ser_dat, acc[7:1]};
                nb++;
                if (nb == 8) begin
                    nb = 0; sb_cnt++;
                    if (exp_q.size() == 0) sb_bad++;
                    else if (exp_q.pop_front() != acc) sb_bad++;
                end
            end else extra++;
            if (bits == drop_at) begin tgt_stat_n = 1'b0; hold_low = 20; end
            if (bits == done_at && !tgt_done) begin
                tgt_done = 1'b1; t_done = cyc; init_cnt = init_dly;
            end
        end
        if (!ser_clk && p_clk && hi_len < HI_MIN) viol++;
        if (ser_clk) hi_len++; else hi_len = 0;
        if (ser_clk && !p_clk) lo_len = 0; else if (!ser_clk) lo_len++;
        if (tgt_done && !tgt_init) begin
            if (init_cnt == 0) begin tgt_init = 1'b1; t_init = cyc; end
            else init_cnt--;
        end
        p_clk = ser_clk; p_dat = ser_dat; p_req = cfg_req_n; p_rdy = tgt_ready;
    end

    task automatic send_bytes(input int n, input int seed, input int gap);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = 8'((seed * 37 + i * 73 + 5) ^ (i << 3));
            exp_q.push_back(b);
            @(negedge clk);
            s_data = b; s_last = (i == n - 1); s_valid = 1'b1;
            while (!s_ready && !abort) @(negedge clk);
            @(negedge clk);
            s_valid = 1'b0; s_last = 1'b0;
            if (abort) break;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
    endtask

    task automatic run(input int n, input int seed, input int gap,
                       input int dn, input int drp, input int idly);
        exp_q.delete();
        exp_bits = 8 * n; nb = 0; sb_cnt = 0; sb_bad = 0; extra = 0; viol = 0;
        done_at = dn; drop_at = drp; init_dly = idly; abort = 1'b0;
        rdy_hi_clk = 0; rises_after_rdy = 0; rises_after_err = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        fork send_bytes(n, seed, gap); join_none
        for (int k = 0; k < 30000; k++) begin
            @(negedge clk);
            if (tgt_ready || cfg_err) break;
        end
        abort = 1'b1;
        for (int k = 0; k < gap + 4; k++) @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < LIMIT; k++) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", cyc, LIMIT);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle levels after reset
        chk(cfg_req_n == 1'b1, "R1", "request line", cfg_req_n, 1);
        chk(!ser_clk && !ser_dat, "R1", "clk/data low", {ser_clk, ser_dat}, 0);
        chk(!s_ready && !tgt_ready && !cfg_err, "R1", "ready/err",
            {s_ready, tgt_ready, cfg_err}, 0);

        // R3: start during target power-on is ignored
        req_lows = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        chk(req_lows == 0, "R3", "request pulses during power-on", req_lows, 0);
        repeat (40) @(negedge clk);

        // run 1: four bytes back to back, init 10 cycles after done
        run(4, 1, 0, 32, -1, 10);
        chk(tgt_ready && !cfg_err, "R8", "run1 completed", tgt_ready, 1);
        chk(t_req_rise - t_req_fall >= REQ_LOW, "R2", "request low width",
            t_req_rise - t_req_fall, REQ_LOW);
        chk(t_first - t_stat >= ST2CK, "R4", "status-to-first-clock",
            t_first - t_stat, ST2CK);
        chk(sb_cnt == 4 && sb_bad == 0, "R5", "bytes matched (bad count)", sb_bad, 0);
        chk(viol == 0, "R6", "setup/hold/phase violations", viol, 0);
        chk(rdy_hi_clk == 0, "R7", "s_ready while clock high", rdy_hi_clk, 0);
        chk(t_rdy - t_done >= UM, "R8", "done-to-ready delay", t_rdy - t_done, UM);
        chk(t_rdy > t_init, "R8", "ready after init", t_rdy, t_init + 1);
        repeat (30) @(negedge clk);
        chk(rises_after_rdy == 0 && !ser_clk && !ser_dat, "R9",
            "clock edges after ready", rises_after_rdy, 0);

        // run 2: restart from ready, throttled source, no init delay
        run(6, 9, 7, 48, -1, 0);
        chk(tgt_ready && !cfg_err, "R12", "restart from ready completed", tgt_ready, 1);
        chk(sb_cnt == 6 && sb_bad == 0, "R5", "throttled bytes (bad count)", sb_bad, 0);
        chk(viol == 0, "R6", "throttled violations", viol, 0);
        chk(rdy_hi_clk == 0, "R7", "throttled s_ready while clock high", rdy_hi_clk, 0);

        // run 3: status drops at bit 12
        run(4, 3, 0, -1, 12, 0);
        chk(cfg_err == 1'b1, "R10", "error on status drop", cfg_err, 1);
        repeat (10) @(negedge clk);
        chk(cfg_req_n && !ser_clk && !tgt_ready, "R10", "idle after drop",
            {cfg_req_n, ser_clk, tgt_ready}, 4);
        chk(rises_after_err == 0, "R10", "clock edges after error", rises_after_err, 0);
        repeat (30) @(negedge clk);

        // run 4: recovery clears the error
        run(3, 5, 2, 24, -1, 3);
        chk(!cfg_err && tgt_ready, "R12", "error cleared by new start", cfg_err, 0);
        chk(sb_cnt == 3 && sb_bad == 0, "R5", "recovery bytes (bad count)", sb_bad, 0);

        // run 5: done never rises
        run(2, 7, 0, -1, -1, 0);
        chk(cfg_err == 1'b1, "R11", "error on missing done", cfg_err, 1);
        chk(extra == EXTRA, "R11", "extra clocks after last byte", extra, EXTRA);
        chk(cfg_req_n && !ser_clk, "R11", "idle after timeout", {cfg_req_n, ser_clk}, 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule